// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the configuration and exception-reporting registers that sit beside a memory-management unit: the translation control word, the page-table-entry high, low and assist words, the translation table base, the exception address, the trap code, and the exception and interrupt event codes. A processor reaches them over a simple 32-bit register bus with one request per cycle. Every request gets exactly one response one cycle later. The stored values are driven out continuously to the translation and exception logic.

Two writes have side effects that the TLB logic elsewhere acts on. Setting the invalidate bit in the control word produces a one-cycle TLB-invalidate pulse, and the bit itself is never stored. Writing a page-table-entry high value whose address-space identifier differs from the stored one produces a one-cycle translation-flush pulse. Narrow registers drop their unused upper bits on write. Accesses of the wrong width and accesses to offsets with no register are refused with an error response.

Top module: `mmureg_bank`

## Requirements
- R1: After reset every register reads back as zero, every register output is zero, and both pulse outputs are low.
- R2: The page-table-entry low (offset 0x08), translation table base (0x0C) and exception address (0x10) registers store and return all 32 written bits.
- R3: The page-table-entry assist register (offset 0x20) keeps written bits [3:0] only, and bits [31:4] always read as zero.
- R4: The trap code (0x14), exception event (0x18) and interrupt event (0x1C) registers keep written bits [10:0] only, and bits [31:11] always read as zero.
- R5: A write to the control register (offset 0x00) with bit 2 set raises `tlb_inv_o` for exactly the cycle in which the write response is valid. Bit 2 is always stored as zero, and all other written bits are stored.
- R6: A write to page-table-entry high (offset 0x04) whose bits [7:0] differ from the stored bits [7:0] raises `asid_flush_o` for exactly the cycle in which the write response is valid. If bits [7:0] are equal, no pulse occurs. In both cases all 32 bits are stored.
- R7: Only accesses with `req_size` = 2 (32-bit) are accepted. Size codes 0 (byte), 1 (half-word) and 3 get `rsp_err` = 1 and `rsp_rdata` = 0, and change no register and raise no pulse.
- R8: An access to an offset that is not one of the nine word offsets 0x00 to 0x20 listed above, including any misaligned offset, gets `rsp_err` = 1 and `rsp_rdata` = 0, and changes no register.
- R9: Each request cycle (`req_valid` = 1) gives exactly one `rsp_valid` cycle on the next clock. A cycle with no request gives no response.
- R10: Reads never raise a pulse, and a write response always returns `rsp_rdata` = 0 and `rsp_err` = 0 when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_size | input | 2 | Access width code: 0 byte, 1 half, 2 word |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | DATA_W (32) | Read data, zero on writes and errors |
| tlb_inv_o | output | 1 | One-cycle full TLB invalidate pulse |
| asid_flush_o | output | 1 | One-cycle translation flush pulse on ASID change |
| ctl_o | output | DATA_W (32) | Stored control word |
| pteh_o | output | DATA_W (32) | Stored page-table-entry high |
| ptel_o | output | DATA_W (32) | Stored page-table-entry low |
| ptea_o | output | DATA_W (32) | Stored page-table-entry assist |
| ttb_o | output | DATA_W (32) | Stored translation table base |
| tea_o | output | DATA_W (32) | Stored exception address |
| trap_o | output | DATA_W (32) | Stored trap code |
| exc_evt_o | output | DATA_W (32) | Stored exception event code |
| int_evt_o | output | DATA_W (32) | Stored interrupt event code |

## Verification
A wrong stored value shows on its register output on the clock after the bad write, and on the bus the next time that offset is read. The scoreboard keeps a model of all nine registers and checks every read against it, so a corruption is reported at the first readback. A lost, doubled or spurious invalidate or flush pulse shows up in the response cycle of the write that caused it, because pulse levels are compared on every cycle. If a refused access still writes a register, the next read of that register shows it, and a wrong refusal shows at once in `rsp_err`.

// File: rtl/mmureg_pkg.sv
package mmureg_pkg;

   // Register slots; slot n decodes at byte offset 4*n.
   localparam int NREG = 9;

   typedef enum logic [3:0] {
      RG_CTL  = 4'd0,
      RG_PTEH = 4'd1,
      RG_PTEL = 4'd2,
      RG_TTB  = 4'd3,
      RG_TEA  = 4'd4,
      RG_TRAP = 4'd5,
      RG_EXC  = 4'd6,
      RG_INT  = 4'd7,
      RG_PTEA = 4'd8
   } reg_id_e;

   // Access width codes on req_size.
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/mmureg_decode.sv
module mmureg_decode
   import mmureg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NSLOT  = NREG
) (
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   output logic [NSLOT-1:0]  hit_o,
   output logic              size_ok_o,
   output logic              mapped_o
);

   // Exact-match decode: a slot hits only on its aligned word offset.
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_OFF = ADDR_W'(i * 4);
      assign hit_o[i] = (req_addr == SLOT_OFF);
   end

   assign size_ok_o = (req_size == SZ_WORD);
   assign mapped_o  = |hit_o;

endmodule

// File: rtl/mmureg_file.sv
module mmureg_file
   import mmureg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NSLOT   = NREG,
   parameter int INV_BIT = 2,
   parameter int EVT_W   = 11,
   parameter int PTEA_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSLOT-1:0]             we,
   input  logic [DATA_W-1:0]            wdata,
   output logic [NSLOT-1:0][DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   // Bits each slot keeps on a write; the rest are forced to zero.
   function automatic logic [DATA_W-1:0] keep_mask(input int slot);
      logic [DATA_W-1:0] m;
      case (slot)
         int'(RG_CTL):  m = ALL_ONES & ~(DATA_W'(1) << INV_BIT);
         int'(RG_TRAP),
         int'(RG_EXC),
         int'(RG_INT):  m = ALL_ONES >> (DATA_W - EVT_W);
         int'(RG_PTEA): m = ALL_ONES >> (DATA_W - PTEA_W);
         default:       m = ALL_ONES;
      endcase
      return m;
   endfunction

   for (genvar i = 0; i < NSLOT; i++) begin : g_reg
      localparam logic [DATA_W-1:0] KEEP = keep_mask(i);
      logic [DATA_W-1:0] r_q;

      if (KEEP == ALL_ONES) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     r_q <= '0;
            else if (we[i]) r_q <= wdata;
         end
      end else begin : g_masked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     r_q <= '0;
            else if (we[i]) r_q <= wdata & KEEP;
         end
      end

      assign q[i] = r_q;
   end

endmodule

// File: rtl/mmureg_side.sv
module mmureg_side #(
   parameter int ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              pteh_wr,
   input  logic              inv_req,
   input  logic [ASID_W-1:0] new_asid,
   input  logic [ASID_W-1:0] cur_asid,
   output logic              tlb_inv_o,
   output logic              asid_flush_o
);

   logic inv_q;
   logic flush_q;

   // cur_asid is the value held before this write's clock edge, so the
   // compare sees the old identifier; the pulse and the store share an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         inv_q   <= ctl_wr & inv_req;
         flush_q <= pteh_wr & (new_asid != cur_asid);
      end
   end

   assign tlb_inv_o    = inv_q;
   assign asid_flush_o = flush_q;

endmodule

// File: rtl/mmureg_bank.sv
module mmureg_bank
   import mmureg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int INV_BIT = 2,
   parameter int ASID_W  = 8,
   parameter int EVT_W   = 11,
   parameter int PTEA_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              tlb_inv_o,
   output logic              asid_flush_o,
   output logic [DATA_W-1:0] ctl_o,
   output logic [DATA_W-1:0] pteh_o,
   output logic [DATA_W-1:0] ptel_o,
   output logic [DATA_W-1:0] ptea_o,
   output logic [DATA_W-1:0] ttb_o,
   output logic [DATA_W-1:0] tea_o,
   output logic [DATA_W-1:0] trap_o,
   output logic [DATA_W-1:0] exc_evt_o,
   output logic [DATA_W-1:0] int_evt_o
);

   localparam int NSLOT   = NREG;
   localparam int TOP_OFF = (NSLOT - 1) * 4;

   // Elaboration-time parameter checks.
   if (DATA_W < 16) begin : g_bad_data_w
      $error("mmureg_bank: DATA_W must be at least 16");
   end
   if (INV_BIT < 0 || INV_BIT >= DATA_W) begin : g_bad_inv_bit
      $error("mmureg_bank: INV_BIT out of range");
   end
   if (ASID_W < 1 || ASID_W > DATA_W) begin : g_bad_asid_w
      $error("mmureg_bank: ASID_W out of range");
   end
   if (EVT_W < 1 || EVT_W >= DATA_W) begin : g_bad_evt_w
      $error("mmureg_bank: EVT_W out of range");
   end
   if (PTEA_W < 1 || PTEA_W >= DATA_W) begin : g_bad_ptea_w
      $error("mmureg_bank: PTEA_W out of range");
   end
   if (TOP_OFF >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("mmureg_bank: ADDR_W too narrow for the register slots");
   end

   logic [NSLOT-1:0]             hit;
   logic                         size_ok;
   logic                         mapped;
   logic                         acc_ok;
   logic                         wr_go;
   logic [NSLOT-1:0]             we;
   logic [NSLOT-1:0][DATA_W-1:0] regs_q;
   logic [DATA_W-1:0]            rd_mux;

   mmureg_decode #(
      .ADDR_W (ADDR_W),
      .NSLOT  (NSLOT)
   ) u_dec (
      .req_addr  (req_addr),
      .req_size  (req_size),
      .hit_o     (hit),
      .size_ok_o (size_ok),
      .mapped_o  (mapped)
   );

   assign acc_ok = size_ok & mapped;
   assign wr_go  = req_valid & req_write & acc_ok;
   assign we     = hit & {NSLOT{wr_go}};

   mmureg_file #(
      .DATA_W  (DATA_W),
      .NSLOT   (NSLOT),
      .INV_BIT (INV_BIT),
      .EVT_W   (EVT_W),
      .PTEA_W  (PTEA_W)
   ) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .wdata (req_wdata),
      .q     (regs_q)
   );

   mmureg_side #(
      .ASID_W (ASID_W)
   ) u_side (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_wr       (we[int'(RG_CTL)]),
      .pteh_wr      (we[int'(RG_PTEH)]),
      .inv_req      (req_wdata[INV_BIT]),
      .new_asid     (req_wdata[ASID_W-1:0]),
      .cur_asid     (regs_q[int'(RG_PTEH)][ASID_W-1:0]),
      .tlb_inv_o    (tlb_inv_o),
      .asid_flush_o (asid_flush_o)
   );

   // One-hot read select; unmatched offsets fall through to zero.
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (hit[i]) rd_mux = rd_mux | regs_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & ~acc_ok;
         rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_mux : '0;
      end
   end

   assign ctl_o     = regs_q[int'(RG_CTL)];
   assign pteh_o    = regs_q[int'(RG_PTEH)];
   assign ptel_o    = regs_q[int'(RG_PTEL)];
   assign ttb_o     = regs_q[int'(RG_TTB)];
   assign tea_o     = regs_q[int'(RG_TEA)];
   assign trap_o    = regs_q[int'(RG_TRAP)];
   assign exc_evt_o = regs_q[int'(RG_EXC)];
   assign int_evt_o = regs_q[int'(RG_INT)];
   assign ptea_o    = regs_q[int'(RG_PTEA)];

endmodule

// File: rtl/mmureg_bank_chk.sv
module mmureg_bank_chk
   import mmureg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int INV_BIT = 2,
   parameter int EVT_W   = 11,
   parameter int PTEA_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              req_inv_bit,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              tlb_inv_o,
   input logic              asid_flush_o,
   input logic [DATA_W-1:0] ctl_o,
   input logic [DATA_W-1:0] pteh_o,
   input logic [DATA_W-1:0] ptea_o,
   input logic [DATA_W-1:0] trap_o,
   input logic [DATA_W-1:0] exc_evt_o,
   input logic [DATA_W-1:0] int_evt_o
);

   localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFF_PTEH = ADDR_W'(4);

   p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_inv_bit_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[INV_BIT] == 1'b0);

   p_inv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == SZ_WORD && req_addr == OFF_CTL
       && req_inv_bit) |=> tlb_inv_o);

   p_inv_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inv_o |-> $past(req_valid && req_write && req_addr == OFF_CTL));

   p_flush_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      asid_flush_o |-> $past(req_valid && req_write && req_addr == OFF_PTEH));

   p_pteh_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(pteh_o));

   p_ptea_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ptea_o[DATA_W-1:PTEA_W] == '0);

   p_evt_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o[DATA_W-1:EVT_W] == '0) && (exc_evt_o[DATA_W-1:EVT_W] == '0)
      && (int_evt_o[DATA_W-1:EVT_W] == '0));

   p_bad_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != SZ_WORD) |=>
      (rsp_err && rsp_rdata == '0 && !tlb_inv_o && !asid_flush_o));

   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));

endmodule

bind mmureg_bank mmureg_bank_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .INV_BIT (INV_BIT),
   .EVT_W   (EVT_W),
   .PTEA_W  (PTEA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .req_size     (req_size),
   .req_inv_bit  (req_wdata[INV_BIT]),
   .rsp_valid    (rsp_valid),
   .rsp_err      (rsp_err),
   .rsp_rdata    (rsp_rdata),
   .tlb_inv_o    (tlb_inv_o),
   .asid_flush_o (asid_flush_o),
   .ctl_o        (ctl_o),
   .pteh_o       (pteh_o),
   .ptea_o       (ptea_o),
   .trap_o       (trap_o),
   .exc_evt_o    (exc_evt_o),
   .int_evt_o    (int_evt_o)
);

// File: tb/mmureg_bank_tb.sv
`timescale 1ns/1ps
module mmureg_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, tlb_inv_o, asid_flush_o;
   logic [31:0] rsp_rdata;
   logic [31:0] ctl_o, pteh_o, ptel_o, ptea_o, ttb_o, tea_o;
   logic [31:0] trap_o, exc_evt_o, int_evt_o;

   always #2 clk = ~clk;   // 250 MHz

   mmureg_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .tlb_inv_o(tlb_inv_o), .asid_flush_o(asid_flush_o),
      .ctl_o(ctl_o), .pteh_o(pteh_o), .ptel_o(ptel_o), .ptea_o(ptea_o),
      .ttb_o(ttb_o), .tea_o(tea_o), .trap_o(trap_o),
      .exc_evt_o(exc_evt_o), .int_evt_o(int_evt_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   // Scoreboard queues (one entry per expected response).
   logic [31:0] q_rd[$];
   bit          q_err[$];
   bit          q_inv[$];
   bit          q_fl[$];
   string       q_tag[$];

   // Reference model of the nine registers, slot n at offset 4*n.
   logic [31:0] mdl [9];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input bit wr, input logic [7:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input string tag);
      int idx;
      bit ok;
      logic [31:0] er;
      bit ei, ef;
      idx = int'(addr >> 2);
      ok  = (addr[1:0] == 2'b00) && (addr <= 8'h20) && (sz == 2'd2);
      er = '0; ei = 1'b0; ef = 1'b0;
      if (ok && !wr) er = mdl[idx];
      if (ok && wr) begin
         case (idx)
            0: begin ei = wd[2]; mdl[0] = wd & ~32'h4; end
            1: begin ef = (wd[7:0] != mdl[1][7:0]); mdl[1] = wd; end
            5, 6, 7: mdl[idx] = wd & 32'h7FF;
            8: mdl[8] = wd & 32'hF;
            default: mdl[idx] = wd;
         endcase
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr;
      req_size = sz; req_wdata = wd;
      q_rd.push_back(er); q_err.push_back(!ok);
      q_inv.push_back(ei); q_fl.push_back(ef); q_tag.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
      req_size = '0; req_wdata = '0;
   endtask

   // Monitor: pops one expected item per response, checks pulses each cycle.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (rsp_valid) begin
               if (q_rd.size() == 0) begin
                  chk(1'b0, "R9", "unexpected response", 32'd1, 32'd0);
               end else begin
                  logic [31:0] er;
                  bit ee, ei, ef;
                  string tg;
                  er = q_rd.pop_front(); ee = q_err.pop_front();
                  ei = q_inv.pop_front(); ef = q_fl.pop_front();
                  tg = q_tag.pop_front();
                  chk(rsp_rdata == er, tg, "rdata", rsp_rdata, er);
                  chk(rsp_err == ee, tg, "err", 32'(rsp_err), 32'(ee));
                  chk(tlb_inv_o == ei, tg, "tlb_inv", 32'(tlb_inv_o), 32'(ei));
                  chk(asid_flush_o == ef, tg, "asid_flush",
                      32'(asid_flush_o), 32'(ef));
               end
            end else begin
               chk(!tlb_inv_o && !asid_flush_o, "R10", "pulse without response",
                   {30'd0, tlb_inv_o, asid_flush_o}, 32'd0);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 9; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1: reset state at the ports
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk(!tlb_inv_o && !asid_flush_o, "R1", "pulses",
          {30'd0, tlb_inv_o, asid_flush_o}, 32'd0);
      chk((ctl_o | pteh_o | ptel_o | ptea_o | ttb_o | tea_o | trap_o
           | exc_evt_o | int_evt_o) == '0, "R1", "register outputs",
          ctl_o | pteh_o | ttb_o, 32'd0);
      mon_on = 1'b1;

      // R1: every slot reads zero
      for (int i = 0; i < 9; i++) drive(1'b0, 8'(i * 4), 2'd2, '0, "R1");

      // R2: full-width registers
      drive(1'b1, 8'h0C, 2'd2, 32'hDEADBEEF, "R2");
      drive(1'b1, 8'h10, 2'd2, 32'hFFFFFFFF, "R2");
      drive(1'b1, 8'h08, 2'd2, 32'h12345678, "R2");
      drive(1'b0, 8'h0C, 2'd2, '0, "R2");
      drive(1'b0, 8'h10, 2'd2, '0, "R2");
      drive(1'b0, 8'h08, 2'd2, '0, "R2");

      // R3: assist register keeps four bits
      drive(1'b1, 8'h20, 2'd2, 32'hFFFFFFFF, "R3");
      drive(1'b0, 8'h20, 2'd2, '0, "R3");
      idle();
      chk(ptea_o == 32'hF, "R3", "ptea_o", ptea_o, 32'hF);

      // R4: event codes keep eleven bits
      drive(1'b1, 8'h14, 2'd2, 32'hFFFFFFFF, "R4");
      drive(1'b1, 8'h18, 2'd2, 32'hABCD1234, "R4");
      drive(1'b1, 8'h1C, 2'd2, 32'h00000800, "R4");
      drive(1'b0, 8'h14, 2'd2, '0, "R4");
      drive(1'b0, 8'h18, 2'd2, '0, "R4");
      drive(1'b0, 8'h1C, 2'd2, '0, "R4");

      // R5: invalidate bit pulses and is not stored
      drive(1'b1, 8'h00, 2'd2, 32'h00000105, "R5");
      drive(1'b0, 8'h00, 2'd2, '0, "R5");
      drive(1'b1, 8'h00, 2'd2, 32'h00000003, "R5");
      drive(1'b1, 8'h00, 2'd2, 32'hFFFFFFFF, "R5");
      drive(1'b1, 8'h00, 2'd2, 32'h00000004, "R5");
      drive(1'b0, 8'h00, 2'd2, '0, "R5");
      idle();
      chk(ctl_o == 32'h0, "R5", "ctl_o", ctl_o, 32'h0);

      // R6: flush only on identifier change
      drive(1'b1, 8'h04, 2'd2, 32'hABCD0000, "R6");
      drive(1'b1, 8'h04, 2'd2, 32'h11112233, "R6");
      drive(1'b1, 8'h04, 2'd2, 32'h99990033, "R6");
      drive(1'b1, 8'h04, 2'd2, 32'h99990034, "R6");
      drive(1'b1, 8'h04, 2'd2, 32'h00000080, "R6");
      drive(1'b0, 8'h04, 2'd2, '0, "R6");
      idle();
      chk(pteh_o == 32'h00000080, "R6", "pteh_o", pteh_o, 32'h00000080);

      // R7: wrong access widths refused with no effect
      drive(1'b1, 8'h0C, 2'd0, 32'h55555555, "R7");
      drive(1'b1, 8'h04, 2'd1, 32'h000000FF, "R7");
      drive(1'b1, 8'h00, 2'd3, 32'h00000004, "R7");
      drive(1'b0, 8'h0C, 2'd1, '0, "R7");
      drive(1'b0, 8'h0C, 2'd2, '0, "R7");
      drive(1'b0, 8'h04, 2'd2, '0, "R7");

      // R8: unmapped and misaligned offsets refused
      drive(1'b1, 8'h24, 2'd2, 32'hCAFEF00D, "R8");
      drive(1'b1, 8'h0D, 2'd2, 32'h0BADF00D, "R8");
      drive(1'b0, 8'hFC, 2'd2, '0, "R8");
      drive(1'b0, 8'h02, 2'd2, '0, "R8");
      drive(1'b0, 8'h0C, 2'd2, '0, "R8");
      idle();
      chk(ttb_o == 32'hDEADBEEF, "R8", "ttb_o", ttb_o, 32'hDEADBEEF);

      // R10: reads never pulse; accepted writes return zero data
      drive(1'b0, 8'h00, 2'd2, 32'hFFFFFFFF, "R10");
      drive(1'b1, 8'h10, 2'd2, 32'h00000001, "R10");
      drive(1'b0, 8'h04, 2'd2, 32'hFFFFFFFF, "R10");
      idle();

      repeat (3) @(posedge clk);
      #1;
      // R9: every request answered exactly once
      chk(q_rd.size() == 0, "R9", "responses outstanding",
          32'(q_rd.size()), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule